// File: doc/BRIEF.md
# Register-Indirect Jump, Link and Hazard-Barrier Unit

This unit sits in the execute stage of a simple in-order 32-bit pipeline that has one branch delay slot. It recognises the register-indirect jump instruction. When the destination register field is nonzero, the instruction acts as a call: it writes a return link of PC + 8 to that register. When the field is zero, it acts as a plain jump. The unit holds the jump target until the delay-slot instruction has issued. It then sends one redirect pulse to fetch, along with the next instruction-set mode bit.

The hazard-barrier form of the jump also asks fetch to discard prefetched instructions, so that fetch and decode restart cleanly at the target. The barrier covers only instructions that came before the jump. The unit also flags three conditions:
- a misaligned target, according to whether a compressed instruction set is configured;
- a control-transfer instruction found in a delay slot, which raises a reserved-instruction exception;
- an encoding whose source and destination registers are the same, which is marked as unpredictable.

The register file, the fetch unit and exception vectoring are outside this block.

Top module: `jr_link_unit`

## Requirements
- R1: An instruction is taken as the jump only when bits 31..26 are 000000, bits 5..0 are 001001 and bits 20..16 are all zero. Any other word produces no link write and no redirect.
- R2: For a jump with destination field rd (bits 15..11) nonzero, the cycle after it issues shows `link_we`=1, `link_idx`=rd and `link_val`=PC+8.
- R3: For a jump with rd = 0, no link write occurs (`link_we`=0), but the redirect still happens.
- R4: `redirect_valid` is a one-cycle pulse. It comes in the cycle after the next issued instruction (the delay slot), however many idle cycles lie between the jump and that instruction.
- R5: With `cfg_compressed`=0, the redirect target is the full rs value and `next_isa_mode`=0. `addr_err` pulses with the redirect when rs bits 1..0 are not 00.
- R6: With `cfg_compressed`=1, the target is rs with bit 0 cleared and `next_isa_mode` is rs bit 0. `addr_err` pulses with the redirect only when rs bits 1..0 are 10.
- R7: `flush_req` pulses together with the redirect exactly when bit 10 of the jump was 1. Bits 9..6 have no effect.
- R8: Control-transfer instructions are the jump of R1 and primary opcodes 000001 to 000111. Such an instruction issued with `in_delay_slot`=1 pulses `ri_exc` in the next cycle. That cycle shows no redirect. The pending jump is dropped, and an offending jump makes no link write.
- R9: For a jump with rd nonzero and rs (bits 25..21) equal to rd, `unpred_enc` pulses with the link write. The link value is still PC+8, and the target is the rs value sampled at issue.
- R10: While reset is applied, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is issuing this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the issuing instruction |
| rs_value | input | 32 | Value read from the source register |
| cfg_compressed | input | 1 | A compressed instruction set is configured |
| in_delay_slot | input | 1 | The issuing instruction occupies a delay slot |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link destination register |
| link_val | output | 32 | Link value |
| redirect_valid | output | 1 | Redirect fetch pulse |
| redirect_target | output | 32 | Fetch target |
| next_isa_mode | output | 1 | Instruction-set mode at the target |
| flush_req | output | 1 | Discard prefetched instructions |
| addr_err | output | 1 | Target fetch address error |
| ri_exc | output | 1 | Reserved-instruction exception |
| unpred_enc | output | 1 | Source equals destination on a linking jump |

## Verification
The jump is issued with rd = 31, with rd = 0 and with rd equal to rs. These cases separate the link, plain-jump and unpredictable paths.

Targets ending in 00, 01, 10 and 11 are issued in both configuration modes. This shows where the two alignment rules and the mode-bit handling differ.

Near-miss encodings are also issued: nonzero bits 20..16, a wrong function code, and set lower hint bits. They confirm that decode and flush depend only on the defined fields.

Jumps and branches placed in flagged delay slots, and an idle gap before a slot, confirm that the exception cancels the redirect and that the redirect waits for the slot instruction.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned OPC_W     = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL  = 6'b000000;
  localparam logic [OPC_W-1:0] FUNCT_JREG   = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_CTI_LO   = 6'b000001;
  localparam logic [OPC_W-1:0] OPC_CTI_HI   = 6'b000111;

  typedef struct packed {
    logic                 is_jump;
    logic                 is_cti;
    logic                 barrier;
    logic [REG_IDX_W-1:0] src;
    logic [REG_IDX_W-1:0] dst;
  } jr_dec_t;
endpackage

// File: rtl/jr_decode.sv
module jr_decode
  import jr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output jr_dec_t            dec
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] funct;
  logic             zero_mid;
  logic             jump_hit;
  logic             branch_hit;

  always_comb begin
    opc        = instr[31:26];
    funct      = instr[5:0];
    zero_mid   = (instr[20:16] == '0);
    jump_hit   = (opc == OPC_SPECIAL) && (funct == FUNCT_JREG) && zero_mid;
    branch_hit = (opc >= OPC_CTI_LO) && (opc <= OPC_CTI_HI);
    dec.is_jump = jump_hit;
    dec.is_cti  = jump_hit || branch_hit;
    dec.barrier = instr[10];
    dec.src     = instr[25:21];
    dec.dst     = instr[15:11];
  end
endmodule

// File: rtl/jr_target.sv
module jr_target #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] rs_value,
  input  logic            cfg_compressed,
  output logic [XLEN-1:0] target,
  output logic            isa_mode,
  output logic            misaligned
);
  logic [XLEN-1:0] tgt_plain;
  logic [XLEN-1:0] tgt_comp;
  logic            err_plain;
  logic            err_comp;

  always_comb begin
    tgt_plain = rs_value;
    err_plain = (rs_value[1:0] != 2'b00);
    tgt_comp  = {rs_value[XLEN-1:1], 1'b0};
    err_comp  = (rs_value[1:0] == 2'b10);
    if (cfg_compressed) begin
      target     = tgt_comp;
      isa_mode   = rs_value[0];
      misaligned = err_comp;
    end else begin
      target     = tgt_plain;
      isa_mode   = 1'b0;
      misaligned = err_plain;
    end
  end
endmodule

// File: rtl/jr_ctrl.sv
module jr_ctrl
  import jr_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned LINK_OFFSET = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  input  logic                 in_delay_slot,
  input  jr_dec_t              dec,
  input  logic [XLEN-1:0]      pc,
  input  logic [XLEN-1:0]      target,
  input  logic                 isa_mode,
  input  logic                 misaligned,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]      link_val,
  output logic                 redirect_valid,
  output logic [XLEN-1:0]      redirect_target,
  output logic                 next_isa_mode,
  output logic                 flush_req,
  output logic                 addr_err,
  output logic                 ri_exc,
  output logic                 unpred_enc
);
  localparam logic [XLEN-1:0] LINK_ADD = XLEN'(LINK_OFFSET);

  logic            pend_q, pend_d;
  logic [XLEN-1:0] ptgt_q;
  logic            pisa_q, pflush_q, perr_q;
  logic            cap_en;
  logic            slot_take, ri_now, links;

  logic                 link_we_d;
  logic [REG_IDX_W-1:0] link_idx_d;
  logic [XLEN-1:0]      link_val_d;
  logic                 rv_d, isa_d, fl_d, ae_d, ri_d, un_d;
  logic [XLEN-1:0]      tgt_d;

  always_comb begin
    ri_now    = issue_valid && in_delay_slot && dec.is_cti;
    slot_take = issue_valid && pend_q;
    cap_en    = issue_valid && dec.is_jump && !ri_now;
    links     = cap_en && (dec.dst != '0);

    if (cap_en)         pend_d = 1'b1;
    else if (slot_take) pend_d = 1'b0;
    else                pend_d = pend_q;

    link_we_d  = links;
    link_idx_d = links ? dec.dst : '0;
    link_val_d = links ? (pc + LINK_ADD) : '0;
    un_d       = links && (dec.src == dec.dst);

    rv_d  = slot_take && !ri_now;
    tgt_d = rv_d ? ptgt_q : '0;
    isa_d = rv_d && pisa_q;
    fl_d  = rv_d && pflush_q;
    ae_d  = rv_d && perr_q;
    ri_d  = ri_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      ptgt_q   <= '0;
      pisa_q   <= 1'b0;
      pflush_q <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (cap_en) begin
        ptgt_q   <= target;
        pisa_q   <= isa_mode;
        pflush_q <= dec.barrier;
        perr_q   <= misaligned;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_we         <= 1'b0;
      link_idx        <= '0;
      link_val        <= '0;
      redirect_valid  <= 1'b0;
      redirect_target <= '0;
      next_isa_mode   <= 1'b0;
      flush_req       <= 1'b0;
      addr_err        <= 1'b0;
      ri_exc          <= 1'b0;
      unpred_enc      <= 1'b0;
    end else begin
      link_we         <= link_we_d;
      link_idx        <= link_idx_d;
      link_val        <= link_val_d;
      redirect_valid  <= rv_d;
      redirect_target <= tgt_d;
      next_isa_mode   <= isa_d;
      flush_req       <= fl_d;
      addr_err        <= ae_d;
      ri_exc          <= ri_d;
      unpred_enc      <= un_d;
    end
  end
endmodule

// File: rtl/jr_link_unit.sv
module jr_link_unit
  import jr_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned LINK_OFFSET = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [XLEN-1:0]      pc,
  input  logic [XLEN-1:0]      rs_value,
  input  logic                 cfg_compressed,
  input  logic                 in_delay_slot,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]      link_val,
  output logic                 redirect_valid,
  output logic [XLEN-1:0]      redirect_target,
  output logic                 next_isa_mode,
  output logic                 flush_req,
  output logic                 addr_err,
  output logic                 ri_exc,
  output logic                 unpred_enc
);
  jr_dec_t         dec;
  logic [XLEN-1:0] tgt;
  logic            isa;
  logic            mis;

  jr_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  jr_target #(.XLEN(XLEN)) u_tgt (
    .rs_value       (rs_value),
    .cfg_compressed (cfg_compressed),
    .target         (tgt),
    .isa_mode       (isa),
    .misaligned     (mis)
  );

  jr_ctrl #(.XLEN(XLEN), .LINK_OFFSET(LINK_OFFSET)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .issue_valid     (issue_valid),
    .in_delay_slot   (in_delay_slot),
    .dec             (dec),
    .pc              (pc),
    .target          (tgt),
    .isa_mode        (isa),
    .misaligned      (mis),
    .link_we         (link_we),
    .link_idx        (link_idx),
    .link_val        (link_val),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target),
    .next_isa_mode   (next_isa_mode),
    .flush_req       (flush_req),
    .addr_err        (addr_err),
    .ri_exc          (ri_exc),
    .unpred_enc      (unpred_enc)
  );
endmodule

// File: rtl/jr_link_unit_chk.sv
module jr_link_unit_chk #(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned LINK_OFFSET = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [XLEN-1:0] pc,
  input logic            link_we,
  input logic [4:0]      link_idx,
  input logic [XLEN-1:0] link_val,
  input logic            redirect_valid,
  input logic            flush_req,
  input logic            addr_err,
  input logic            ri_exc,
  input logic            unpred_enc
);
  assert_link_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> ($past(issue_valid) && link_val == $past(pc) + XLEN'(LINK_OFFSET)));

  assert_no_zero_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx != 5'd0));

  assert_redirect_after_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(issue_valid));

  assert_err_with_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> redirect_valid);

  assert_flush_with_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> redirect_valid);

  assert_ri_blocks_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ri_exc |-> (!redirect_valid && !link_we));

  assert_unpred_with_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_enc |-> link_we);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!link_we && !redirect_valid && !flush_req && !ri_exc);
    end
  end
endmodule

bind jr_link_unit jr_link_unit_chk #(.XLEN(XLEN), .LINK_OFFSET(LINK_OFFSET)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .issue_valid    (issue_valid),
  .pc             (pc),
  .link_we        (link_we),
  .link_idx       (link_idx),
  .link_val       (link_val),
  .redirect_valid (redirect_valid),
  .flush_req      (flush_req),
  .addr_err       (addr_err),
  .ri_exc         (ri_exc),
  .unpred_enc     (unpred_enc)
);

// File: tb/test_jr_link_unit.sv
`timescale 1ns/1ps
module test_jr_link_unit;
  logic        clk, rst_n;
  logic        issue_valid, cfg_compressed, in_delay_slot;
  logic [31:0] instr, pc, rs_value;
  logic        link_we, redirect_valid, next_isa_mode, flush_req, addr_err, ri_exc, unpred_enc;
  logic [4:0]  link_idx;
  logic [31:0] link_val, redirect_target;

  typedef struct packed {
    logic        we;
    logic [4:0]  idx;
    logic [31:0] val;
    logic        rv;
    logic [31:0] tgt;
    logic        isa;
    logic        fl;
    logic        ae;
    logic        ri;
    logic        un;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks, fails;
  bit    drv_done;

  bit          m_pend;
  logic [31:0] m_tgt;
  bit          m_isa, m_fl, m_ae;

  jr_link_unit i_jr_link_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr), .pc(pc),
    .rs_value(rs_value), .cfg_compressed(cfg_compressed), .in_delay_slot(in_delay_slot),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .next_isa_mode(next_isa_mode), .flush_req(flush_req), .addr_err(addr_err),
    .ri_exc(ri_exc), .unpred_enc(unpred_enc));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk_jr(input logic [4:0] rs, input logic [4:0] rd,
                                        input logic hb, input logic [3:0] low);
    return {6'b000000, rs, 5'b00000, rd, hb, low, 6'b001001};
  endfunction

  function automatic exp_t act();
    exp_t a;
    a.we = link_we; a.idx = link_idx; a.val = link_val; a.rv = redirect_valid;
    a.tgt = redirect_target; a.isa = next_isa_mode; a.fl = flush_req;
    a.ae = addr_err; a.ri = ri_exc; a.un = unpred_enc;
    return a;
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] p,
                      input logic [31:0] rs, input logic comp, input logic ds, input string tag);
    exp_t e;
    bit   is_j, cti, ri;
    @(negedge clk);
    issue_valid = v; instr = ins; pc = p; rs_value = rs;
    cfg_compressed = comp; in_delay_slot = ds;
    e    = '0;
    is_j = (ins[31:26] == 6'd0) && (ins[5:0] == 6'b001001) && (ins[20:16] == 5'd0);
    cti  = is_j || (ins[31:26] >= 6'd1 && ins[31:26] <= 6'd7);
    ri   = v && ds && cti;
    if (v) begin
      e.ri = ri;
      if (m_pend) begin
        if (!ri) begin
          e.rv = 1'b1; e.tgt = m_tgt; e.isa = m_isa; e.fl = m_fl; e.ae = m_ae;
        end
        m_pend = 1'b0;
      end
      if (is_j && !ri) begin
        if (ins[15:11] != 5'd0) begin
          e.we = 1'b1; e.idx = ins[15:11]; e.val = p + 32'd8;
          e.un = (ins[25:21] == ins[15:11]);
        end
        m_pend = 1'b1;
        m_fl   = ins[10];
        if (comp) begin
          m_tgt = {rs[31:1], 1'b0}; m_isa = rs[0]; m_ae = (rs[1:0] == 2'b10);
        end else begin
          m_tgt = rs; m_isa = 1'b0; m_ae = (rs[1:0] != 2'b00);
        end
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin : monitor
    exp_t  e, a;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = act();
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!drv_done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    checks = 0; fails = 0; drv_done = 0; m_pend = 0;
    m_tgt = '0; m_isa = 0; m_fl = 0; m_ae = 0;
    rst_n = 1'b0; issue_valid = 0; instr = 0; pc = 0; rs_value = 0;
    cfg_compressed = 0; in_delay_slot = 0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (act() !== exp_t'(0)) begin
      fails++;
      $display("FAIL R10 reset: actual %h expected 0", act());
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R7: linking jump with barrier, nop slot
    step(1, mk_jr(5'd4, 5'd31, 1'b1, 4'h0), 32'h0000_1000, 32'h0000_2000, 0, 0, "R2 link rd31");
    step(1, 32'd0, 32'h0000_1004, 32'd0, 0, 1, "R7 flush with redirect");
    idle("R4 single pulse");
    // R3 R7: plain jump, lower hint bits set, no flush
    step(1, mk_jr(5'd5, 5'd0, 1'b0, 4'hF), 32'h0000_3000, 32'h0000_4000, 0, 0, "R3 no link");
    step(1, 32'd0, 32'h0000_3004, 32'd0, 0, 1, "R7 low hint ignored");
    // R5 non-compressed misalign 01 and 10
    step(1, mk_jr(5'd6, 5'd2, 1'b0, 4'h0), 32'h0000_5000, 32'h0000_6001, 0, 0, "R5 link");
    step(1, 32'd0, 32'h0000_5004, 32'd0, 0, 1, "R5 err low01");
    step(1, mk_jr(5'd6, 5'd0, 1'b0, 4'h0), 32'h0000_5100, 32'h0000_6002, 0, 0, "R5 issue");
    step(1, 32'd0, 32'h0000_5104, 32'd0, 0, 1, "R5 err low10");
    // R6 compressed: 11 is legal odd target, 10 is error, 01 legal
    step(1, mk_jr(5'd7, 5'd3, 1'b0, 4'h0), 32'h0000_7000, 32'h0000_8003, 1, 0, "R6 issue");
    step(1, 32'd0, 32'h0000_7004, 32'd0, 1, 1, "R6 low11 mode1");
    step(1, mk_jr(5'd7, 5'd0, 1'b1, 4'h0), 32'h0000_7100, 32'h0000_8002, 1, 0, "R6 issue");
    step(1, 32'd0, 32'h0000_7104, 32'd0, 1, 1, "R6 low10 err");
    step(1, mk_jr(5'd7, 5'd0, 1'b0, 4'h0), 32'h0000_7200, 32'h0000_8001, 1, 0, "R6 issue");
    step(1, 32'd0, 32'h0000_7204, 32'd0, 1, 1, "R6 low01 ok");
    // R1 near misses
    step(1, mk_jr(5'd4, 5'd31, 1'b1, 4'h0) | 32'h0001_0000, 32'h0000_9000, 32'h0000_A000, 0, 0, "R1 mid bits");
    step(1, 32'd0, 32'h0000_9004, 32'd0, 0, 1, "R1 no redirect");
    step(1, {mk_jr(5'd4, 5'd31, 1'b0, 4'h0)} ^ 32'h0000_0001, 32'h0000_9100, 32'h0000_A000, 0, 0, "R1 funct");
    step(1, 32'd0, 32'h0000_9104, 32'd0, 0, 1, "R1 no redirect");
    // R4 idle gap before slot
    step(1, mk_jr(5'd8, 5'd9, 1'b1, 4'h0), 32'h0000_B000, 32'h0000_C000, 0, 0, "R4 issue");
    idle("R4 gap1");
    idle("R4 gap2");
    step(1, 32'd0, 32'h0000_B004, 32'd0, 0, 1, "R4 slot");
    idle("R4 after");
    // R8 jump in delay slot, branch in delay slot
    step(1, mk_jr(5'd8, 5'd0, 1'b0, 4'h0), 32'h0000_D000, 32'h0000_E000, 0, 0, "R8 issue");
    step(1, mk_jr(5'd10, 5'd31, 1'b1, 4'h0), 32'h0000_D004, 32'h0000_F000, 0, 1, "R8 jump in slot");
    idle("R8 no later redirect");
    step(1, mk_jr(5'd8, 5'd0, 1'b0, 4'h0), 32'h0000_D100, 32'h0000_E100, 0, 0, "R8 issue");
    step(1, 32'h1085_0004, 32'h0000_D104, 32'd0, 0, 1, "R8 branch in slot");
    idle("R8 quiet");
    // R9 rs equals rd
    step(1, mk_jr(5'd12, 5'd12, 1'b0, 4'h0), 32'h0001_0000, 32'h0002_0000, 0, 0, "R9 unpred");
    step(1, 32'd0, 32'h0001_0004, 32'hDEAD_BEE0, 0, 1, "R9 target uses old rs");
    idle("R9 tail");
    idle("tail");
    @(posedge clk);
    #3;
    drv_done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule